// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block accepts a stream of 24-bit pixels, one on every pixel clock, and spreads it over one or two output ports. A line starts at the rising edge of the horizontal sync input. The first pixel of each line fixes the odd/even phase that decides which port takes each later pixel. A set of mode inputs chooses between one port and two. In two-port mode it also chooses whether the ports update in turn or together as pairs, and which port takes the first pixel of a line. A further mode packs luma and alternating chroma into 16 bits.

Each port has an update strobe, and a data-clock tick marks every cycle on which any port loads new data. A separate output tells the pad logic to put the second port into high impedance while single-port mode is active. Mode inputs are sampled only at a line start, so a line is never split between two modes.

Pixel input lanes: red in bits [23:16], green in bits [15:8], blue in bits [7:0].

Top module: `pixout_demux`

## Requirements
- R1: After reset both port data outputs are zero, both update strobes and the data-clock tick are 0, and the high-impedance output is 0. The reset mode is two-port, paired updates, first pixel to port A, and no 4:2:2 packing.
- R2: In single-port mode every pixel appears on port A with porta_upd high, two pixel clocks after it enters. Port B does not update and portb_hiz is 1.
- R3: In single-port mode the paired-update and swap inputs have no effect on any output.
- R4: A line starts when hsync_in goes from 0 to 1. The pixel presented on that same cycle is sample 1. The odd/even count restarts at every such edge, whatever the length of the previous line.
- R5: In two-port turn-taking mode with swap 0, odd samples go to port A and even samples go to port B, two pixel clocks after entry. Only the receiving port strobes, and the other port holds its data.
- R6: With swap 1 in two-port mode, the port roles of R5 and R7 are exchanged: odd samples go to port B and even samples go to port A.
- R7: In two-port paired mode, each odd sample and the even sample after it appear together. Both ports strobe on the same cycle, two pixel clocks after the even sample enters. No strobe occurs on the cycle that follows.
- R8: In 4:2:2 mode an output word carries zero in bits [23:16] and the input green in bits [15:8]. Bits [7:0] carry the input blue for odd samples and the input red for even samples.
- R9: A change on any mode input takes effect from the next hsync rising edge. Pixels before that edge keep the previous mode.
- R10: dck_tick is 1 exactly on the cycles on which porta_upd or portb_upd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 = two-port output, 0 = port A only |
| cfg_simul | input | 1 | 1 = ports update together as pairs, 0 = in turn |
| cfg_swap | input | 1 | 1 = first pixel of a line goes to port B |
| cfg_pack422 | input | 1 | 1 = 16-bit luma plus alternating chroma |
| hsync_in | input | 1 | Horizontal sync, active high |
| pix_in | input | 24 | Input pixel, red/green/blue lanes |
| porta_data | output | 24 | Port A data |
| portb_data | output | 24 | Port B data |
| porta_upd | output | 1 | Port A loaded new data this cycle |
| portb_upd | output | 1 | Port B loaded new data this cycle |
| portb_hiz | output | 1 | 1 = drive port B to high impedance |
| dck_tick | output | 1 | Output data-clock tick |

## Verification
A pixel presented before rising edge t is registered at t and reaches the ports at edge t+1. In paired mode the odd sample waits in a holding register and leaves together with its partner. The bench therefore drives and samples on falling edges. For every pixel it computes the expected port state from the requirements and compares it two falling edges later, including the cycles on which a port must hold. Mode changes are computed as taking effect only on the pixel that carries the sync rising edge, so a design that switches mid-line is caught on the following samples.

// File: rtl/pixout_pkg.sv
package pixout_pkg;

    parameter int CH_W  = 8;
    localparam int PIX_W = 3 * CH_W;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

    typedef struct packed {
        logic dual;
        logic simul;
        logic swap;
        logic pack422;
    } mode_t;

    localparam mode_t MODE_RST = '{dual: 1'b1, simul: 1'b1, swap: 1'b0, pack422: 1'b0};

    typedef struct packed {
        pix_t  pix;
        slot_e slot;
        mode_t mode;
    } stage_t;

    // luma stays on green; chroma lane takes blue on first slot, red on second
    function automatic pix_t pack_pixel(input pix_t p, input logic pk, input slot_e s);
        pix_t r;
        if (!pk) begin
            r = p;
        end else begin
            r = '0;
            r[2*CH_W-1:CH_W] = p[2*CH_W-1:CH_W];
            r[CH_W-1:0] = (s == SLOT_FIRST) ? p[CH_W-1:0] : p[3*CH_W-1:2*CH_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/pixout_line.sv
module pixout_line
    import pixout_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hsync_in,
    input  pix_t   pix_in,
    input  mode_t  mode_in,
    output stage_t stage_o
);

    pix_t  pix_q;
    logic  hs_q;
    logic  hs_prev_q;
    slot_e slot_q;
    mode_t mode_q;

    logic  lead;
    slot_e slot_cur;
    mode_t mode_eff;

    always_comb begin
        lead     = hs_q & ~hs_prev_q;
        slot_cur = lead ? SLOT_FIRST : slot_q;
        mode_eff = lead ? mode_in : mode_q;
        stage_o.pix  = pack_pixel(pix_q, mode_eff.pack422, slot_cur);
        stage_o.slot = slot_cur;
        stage_o.mode = mode_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q     <= '0;
            hs_q      <= 1'b0;
            hs_prev_q <= 1'b0;
            slot_q    <= SLOT_FIRST;
            mode_q    <= MODE_RST;
        end else begin
            pix_q     <= pix_in;
            hs_q      <= hsync_in;
            hs_prev_q <= hs_q;
            slot_q    <= (slot_cur == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
            mode_q    <= mode_eff;
        end
    end

endmodule

// File: rtl/pixout_route.sv
module pixout_route
    import pixout_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage_t           stage_i,
    output logic [PIX_W-1:0] porta_o,
    output logic [PIX_W-1:0] portb_o,
    output logic             upda_o,
    output logic             updb_o,
    output logic             hiz_o,
    output logic             dck_o
);

    localparam int NPORT = 2;

    pix_t hold_q;
    logic hiz_q;
    logic dck_q;
    pix_t pdat [NPORT];
    logic pupd [NPORT];
    logic pld  [NPORT];

    logic first_port;
    logic second_slot;
    logic pair_mode;

    always_comb begin
        first_port  = stage_i.mode.swap;
        second_slot = (stage_i.slot == SLOT_SECOND);
        pair_mode   = stage_i.mode.dual & stage_i.mode.simul;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic ld;
        pix_t nx;
        pix_t q;
        logic u;

        always_comb begin
            ld = 1'b0;
            nx = q;
            if (!stage_i.mode.dual) begin
                if (p == 0) begin
                    ld = 1'b1;
                    nx = stage_i.pix;
                end
            end else if (!stage_i.mode.simul) begin
                if ((second_slot ^ first_port) == 1'(p)) begin
                    ld = 1'b1;
                    nx = stage_i.pix;
                end
            end else if (second_slot) begin
                ld = 1'b1;
                nx = (first_port == 1'(p)) ? hold_q : stage_i.pix;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                u <= 1'b0;
            end else begin
                q <= nx;
                u <= ld;
            end
        end

        assign pdat[p] = q;
        assign pupd[p] = u;
        assign pld[p]  = ld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hiz_q  <= 1'b0;
            dck_q  <= 1'b0;
        end else begin
            if (pair_mode && !second_slot) begin
                hold_q <= stage_i.pix;
            end
            hiz_q <= ~stage_i.mode.dual;
            dck_q <= pld[0] | pld[1];
        end
    end

    assign porta_o = pdat[0];
    assign portb_o = pdat[1];
    assign upda_o  = pupd[0];
    assign updb_o  = pupd[1];
    assign hiz_o   = hiz_q;
    assign dck_o   = dck_q;

endmodule

// File: rtl/pixout_demux.sv
module pixout_demux
    import pixout_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dual,
    input  logic             cfg_simul,
    input  logic             cfg_swap,
    input  logic             cfg_pack422,
    input  logic             hsync_in,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] porta_data,
    output logic [PIX_W-1:0] portb_data,
    output logic             porta_upd,
    output logic             portb_upd,
    output logic             portb_hiz,
    output logic             dck_tick
);

    mode_t  mode_in;
    stage_t stage;

    always_comb begin
        mode_in.dual    = cfg_dual;
        mode_in.simul   = cfg_simul;
        mode_in.swap    = cfg_swap;
        mode_in.pack422 = cfg_pack422;
    end

    pixout_line u_line (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .pix_in   (pix_in),
        .mode_in  (mode_in),
        .stage_o  (stage)
    );

    pixout_route u_route (
        .clk     (clk),
        .rst     (rst),
        .stage_i (stage),
        .porta_o (porta_data),
        .portb_o (portb_data),
        .upda_o  (porta_upd),
        .updb_o  (portb_upd),
        .hiz_o   (portb_hiz),
        .dck_o   (dck_tick)
    );

endmodule

// File: rtl/pixout_demux_chk.sv
module pixout_demux_chk
    import pixout_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [PIX_W-1:0] porta_data,
    input logic [PIX_W-1:0] portb_data,
    input logic             porta_upd,
    input logic             portb_upd,
    input logic             portb_hiz
);

    // R2
    hiz_blocks_b_chk: assert property (@(posedge clk) disable iff (rst)
        portb_hiz |-> !portb_upd);

    // R2
    single_feeds_a_chk: assert property (@(posedge clk) disable iff (rst)
        portb_hiz |-> porta_upd);

    // R7
    pair_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (porta_upd && portb_upd) |=> !(porta_upd && portb_upd));

    // R5
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !porta_upd |-> $stable(porta_data));

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !portb_upd |-> $stable(portb_data));

endmodule

bind pixout_demux pixout_demux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .porta_data (porta_data),
    .portb_data (portb_data),
    .porta_upd  (porta_upd),
    .portb_upd  (portb_upd),
    .portb_hiz  (portb_hiz)
);

// File: tb/sim_pixout_demux.sv
`timescale 1ns/1ps
module sim_pixout_demux;
    import pixout_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cfg_dual, cfg_simul, cfg_swap, cfg_pack422, hsync_in;
    logic [PIX_W-1:0] pix_in, porta_data, portb_data;
    logic porta_upd, portb_upd, portb_hiz, dck_tick;

    pixout_demux u0 (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_simul(cfg_simul),
        .cfg_swap(cfg_swap), .cfg_pack422(cfg_pack422), .hsync_in(hsync_in),
        .pix_in(pix_in), .porta_data(porta_data), .portb_data(portb_data),
        .porta_upd(porta_upd), .portb_upd(portb_upd), .portb_hiz(portb_hiz),
        .dck_tick(dck_tick)
    );

    int checks = 0;
    int fails  = 0;
    int k      = 0;

    // expectation model state
    logic m_prev_hs = 1'b0;
    logic m_pos_n   = 1'b0;
    logic m_dual = 1'b1, m_simul = 1'b1, m_swap = 1'b0, m_pk = 1'b0;
    logic [PIX_W-1:0] m_hold = '0, m_a = '0, m_b = '0;

    logic [PIX_W-1:0] xa [256];
    logic [PIX_W-1:0] xb [256];
    logic xua [256];
    logic xub [256];
    logic xhiz [256];
    logic xdck [256];
    string xtag [256];

    task automatic chk(input string tag, input string what,
                       input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [PIX_W-1:0] mkpix(input int x);
        return {8'(x * 7 + 1), 8'(x * 3 + 5), 8'(x * 11 + 9)};
    endfunction

    task automatic model_step(input logic hs, input logic [PIX_W-1:0] p,
                              input bit store, input int idx, input string tag);
        logic lead, pos, ua, ub, tgt;
        logic [PIX_W-1:0] f;
        lead = hs & ~m_prev_hs;
        m_prev_hs = hs;
        if (lead) begin
            m_dual = cfg_dual; m_simul = cfg_simul; m_swap = cfg_swap; m_pk = cfg_pack422;
        end
        pos = lead ? 1'b0 : m_pos_n;
        m_pos_n = ~pos;
        // R8 lane layout
        f = m_pk ? {8'h00, p[15:8], (pos ? p[23:16] : p[7:0])} : p;
        ua = 1'b0; ub = 1'b0;
        if (!m_dual) begin
            ua = 1'b1; m_a = f;
        end else if (!m_simul) begin
            tgt = pos ^ m_swap;
            if (!tgt) begin ua = 1'b1; m_a = f; end
            else      begin ub = 1'b1; m_b = f; end
        end else if (!pos) begin
            m_hold = f;
        end else begin
            ua = 1'b1; ub = 1'b1;
            if (!m_swap) begin m_a = m_hold; m_b = f; end
            else         begin m_b = m_hold; m_a = f; end
        end
        if (store) begin
            xa[idx] = m_a; xb[idx] = m_b; xua[idx] = ua; xub[idx] = ub;
            xhiz[idx] = ~m_dual; xdck[idx] = ua | ub; xtag[idx] = tag;
        end
    endtask

    task automatic step(input logic hs, input logic [PIX_W-1:0] p, input string tag);
        @(negedge clk);
        if (k >= 2) begin
            int j;
            j = (k - 2) % 256;
            chk(xtag[j], "porta_data", porta_data, xa[j]);
            chk(xtag[j], "portb_data", portb_data, xb[j]);
            chk(xtag[j], "porta_upd", PIX_W'(porta_upd), PIX_W'(xua[j]));
            chk(xtag[j], "portb_upd", PIX_W'(portb_upd), PIX_W'(xub[j]));
            chk(xtag[j], "portb_hiz", PIX_W'(portb_hiz), PIX_W'(xhiz[j]));
            chk("R10", "dck_tick", PIX_W'(dck_tick), PIX_W'(xdck[j]));
        end
        hsync_in = hs;
        pix_in   = p;
        model_step(hs, p, 1'b1, k % 256, tag);
        k++;
    endtask

    task automatic set_cfg(input logic d, input logic s, input logic w, input logic pk);
        cfg_dual = d; cfg_simul = s; cfg_swap = w; cfg_pack422 = pk;
    endtask

    task automatic line(input int n, input int seed, input string tag);
        for (int i = 0; i < n; i++) step(i < 2, mkpix(seed + i), tag);
    endtask

    task automatic t_reset;
        rst = 1'b1; hsync_in = 1'b0; pix_in = '0;
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "porta_data", porta_data, '0);
        chk("R1", "portb_data", portb_data, '0);
        chk("R1", "porta_upd", PIX_W'(porta_upd), '0);
        chk("R1", "portb_upd", PIX_W'(portb_upd), '0);
        chk("R1", "portb_hiz", PIX_W'(portb_hiz), '0);
        chk("R1", "dck_tick", PIX_W'(dck_tick), '0);
        rst = 1'b0;
        model_step(1'b0, '0, 1'b0, 0, "R1");
        model_step(1'b0, '0, 1'b0, 0, "R1");
        // default paired mode with no sync yet
        for (int i = 0; i < 4; i++) step(1'b0, mkpix(200 + i), "R1");
    endtask

    task automatic t_single;
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        line(6, 10, "R2");
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        line(5, 30, "R3");
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
        line(4, 40, "R3");
    endtask

    task automatic t_interleave;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        line(5, 50, "R5");
        line(5, 60, "R4");
        line(3, 70, "R4");
        line(6, 75, "R5");
    endtask

    task automatic t_swap;
        set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        line(6, 80, "R6");
        line(5, 90, "R6");
        set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        line(6, 95, "R6");
    endtask

    task automatic t_simul;
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        line(6, 100, "R7");
        line(5, 110, "R7");
        line(7, 115, "R7");
    endtask

    task automatic t_pack;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b1);
        line(6, 130, "R8");
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
        line(5, 140, "R8");
        set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
        line(6, 150, "R8");
    endtask

    task automatic t_cfg_change;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        line(3, 160, "R9");
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, mkpix(170 + i), "R9");
        line(5, 180, "R9");
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, mkpix(190 + i), "R9");
        line(4, 195, "R9");
        step(1'b0, '0, "R9");
        step(1'b0, '0, "R9");
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_interleave();
        t_swap();
        t_simul();
        t_pack();
        t_cfg_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule